// File: doc/BRIEF.md
# Peripheral Register Write-Guard Filter

The filter sits on the byte-wide peripheral-register bus between a processor and the register file it controls. It owns one 8-bit guard control register. Three of its bits each arm write protection for a group of registers: port setup, interrupt control, and the clock, supply-monitor and memory-parity controls. While a group is armed, any write that targets one of its addresses is stopped before it reaches the register file, and the filter raises a violation pulse in that same cycle. Reads are never filtered. The guard register can always be written, so software can arm and disarm the groups at any time.

Parameters map addresses to groups. Each group has a set of inclusive address ranges. A separate range set covers the port data registers; these stay writable even when the port group is armed. Addresses outside every range are never guarded. The register also holds an access-detection enable and a two-bit RAM-guard field. The filter stores them and returns them on reads, but they have no effect on filtering.

Top module: `wg_filter`

## Requirements
- R1: After reset the guard register reads 8'h00, and writes to addresses in every group reach the register file.
- R2: The guard register sits at CTRL_ADDR (default 20'hF0078). A write stores bits 7, 5, 4, 2, 1 and 0. Bits 6 and 3 always read as 0. Reading CTRL_ADDR returns the stored value on cpu_rdata. Accesses to CTRL_ADDR never assert per_we or per_re.
- R3: The guard register is never write-protected. Writes to it take effect whatever its current value is, including 8'hB7.
- R4: While bit 2 is 1, a write to a port-setup address never asserts per_we. The default ranges are 20'hF0010–F003F and 20'hF0060–F006F.
- R5: A write to a port data address always asserts per_we, even while bit 2 is 1. The default ranges are 20'hF0000–F000F and 20'hF0050–F005F.
- R6: While bit 1 is 1, a write to an interrupt-control address never asserts per_we. The default ranges are 20'hF00E0–F00FF and 20'hF0040–F004F.
- R7: While bit 0 is 1, a write to a clock/monitor/parity address never asserts per_we. The default ranges are 20'hF00A0–F00AF and 20'hF0080–F008F.
- R8: A write to an address outside every range always asserts per_we.
- R9: guard_viol is 1 in exactly the cycles in which a write is blocked. The pulse is combinational and arrives with the blocked write.
- R10: For every address other than CTRL_ADDR, per_re equals cpu_re and cpu_rdata equals per_rdata, whatever the guard bits are.
- R11: per_addr and per_wdata always equal cpu_addr and cpu_wdata.
- R12: Bits 7, 5 and 4 of the guard register have no effect on blocking or on guard_viol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | ADDR_W | Bus address |
| cpu_wdata | input | 8 | Bus write data |
| cpu_we | input | 1 | Bus write strobe |
| cpu_re | input | 1 | Bus read strobe |
| cpu_rdata | output | 8 | Read data returned to the processor |
| per_addr | output | ADDR_W | Address forwarded to the register file |
| per_wdata | output | 8 | Write data forwarded to the register file |
| per_we | output | 1 | Gated write strobe |
| per_re | output | 1 | Forwarded read strobe |
| per_rdata | input | 8 | Read data from the register file |
| guard_viol | output | 1 | One-cycle pulse on a blocked write |

## Verification
The read and write strobes may both be high in one cycle. A read that passes through can then coincide with a write to the same guarded address that is blocked and flagged. The random phase raises both strobes independently, with addresses drawn from every range and from the gaps between them. In each such cycle the bench checks per_re and cpu_rdata against the read-forwarding rule, and per_we and guard_viol against the blocking rule, all in the same sample. A directed sequence also rewrites the guard register and then writes a guarded address in the very next cycle, which shows that a new guard setting applies from the following access onward.

// File: rtl/wg_pkg.sv
package wg_pkg;

    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_PORT = 2'd1,
        GRP_INTR = 2'd2,
        GRP_CLK  = 2'd3
    } wg_grp_e;

    typedef struct packed {
        logic    ctrl_hit;
        logic    pdata_hit;
        wg_grp_e grp;
    } wg_class_t;

    localparam int unsigned GUARD_W   = 8;
    localparam int unsigned BIT_PORT  = 2;
    localparam int unsigned BIT_INTR  = 1;
    localparam int unsigned BIT_CLK   = 0;
    localparam logic [GUARD_W-1:0] GUARD_WMASK = 8'hB7;

endpackage

// File: rtl/wg_addr_class.sv
module wg_addr_class
    import wg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned N_RANGES = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 20'hF0078,
    parameter logic [N_RANGES*ADDR_W-1:0] PDATA_LO = {20'hF0050, 20'hF0000},
    parameter logic [N_RANGES*ADDR_W-1:0] PDATA_HI = {20'hF005F, 20'hF000F},
    parameter logic [N_RANGES*ADDR_W-1:0] PORT_LO  = {20'hF0060, 20'hF0010},
    parameter logic [N_RANGES*ADDR_W-1:0] PORT_HI  = {20'hF006F, 20'hF003F},
    parameter logic [N_RANGES*ADDR_W-1:0] INTR_LO  = {20'hF0040, 20'hF00E0},
    parameter logic [N_RANGES*ADDR_W-1:0] INTR_HI  = {20'hF004F, 20'hF00FF},
    parameter logic [N_RANGES*ADDR_W-1:0] CLK_LO   = {20'hF0080, 20'hF00A0},
    parameter logic [N_RANGES*ADDR_W-1:0] CLK_HI   = {20'hF008F, 20'hF00AF}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output wg_class_t         cls
);

    localparam int unsigned N_SETS = 4;
    localparam int unsigned SET_PDATA = 0;
    localparam int unsigned SET_PORT  = 1;
    localparam int unsigned SET_INTR  = 2;
    localparam int unsigned SET_CLK   = 3;

    logic [N_RANGES-1:0] hit_v [N_SETS];
    logic [N_SETS-1:0]   set_hit;

    for (genvar r = 0; r < N_RANGES; r++) begin : g_range
        assign hit_v[SET_PDATA][r] = (addr >= PDATA_LO[r*ADDR_W +: ADDR_W]) &&
                                     (addr <= PDATA_HI[r*ADDR_W +: ADDR_W]);
        assign hit_v[SET_PORT][r]  = (addr >= PORT_LO[r*ADDR_W +: ADDR_W]) &&
                                     (addr <= PORT_HI[r*ADDR_W +: ADDR_W]);
        assign hit_v[SET_INTR][r]  = (addr >= INTR_LO[r*ADDR_W +: ADDR_W]) &&
                                     (addr <= INTR_HI[r*ADDR_W +: ADDR_W]);
        assign hit_v[SET_CLK][r]   = (addr >= CLK_LO[r*ADDR_W +: ADDR_W]) &&
                                     (addr <= CLK_HI[r*ADDR_W +: ADDR_W]);
    end

    for (genvar s = 0; s < N_SETS; s++) begin : g_set
        assign set_hit[s] = |hit_v[s];
    end

    // Priority: guard register, port data exemption, then the three groups.
    always_comb begin
        cls           = '0;
        cls.grp       = GRP_NONE;
        cls.ctrl_hit  = (addr == CTRL_ADDR);
        cls.pdata_hit = !cls.ctrl_hit && set_hit[SET_PDATA];
        if (!cls.ctrl_hit && !cls.pdata_hit) begin
            if (set_hit[SET_PORT])      cls.grp = GRP_PORT;
            else if (set_hit[SET_INTR]) cls.grp = GRP_INTR;
            else if (set_hit[SET_CLK])  cls.grp = GRP_CLK;
        end
    end

    // R8: groups must not overlap, so an address maps to at most one group
    assert_ranges_disjoint_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_hit));

    // R3: the guard register address is never classified into a guarded group
    assert_ctrl_unguarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == CTRL_ADDR) |-> (cls.grp == GRP_NONE));

endmodule

// File: rtl/wg_ctrl_reg.sv
module wg_ctrl_reg
    import wg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [GUARD_W-1:0] wr_data,
    output logic [GUARD_W-1:0] ctrl_q
);

    typedef struct packed {
        logic [GUARD_W-1:0] ctrl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl = wr_data & GUARD_WMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q = st_q.ctrl;

    // R1: reset leaves every guard disarmed
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == 8'h00));

    // R3: a write to the guard register always lands on the guard bits
    assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q[2:0] == $past(wr_data[2:0])));

    // R2: without a write the register holds its value
    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/wg_gate.sv
module wg_gate
    import wg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wg_class_t cls,
    input  logic [2:0] guard_en,
    input  logic      cpu_we,
    input  logic      cpu_re,
    output logic      per_we,
    output logic      per_re,
    output logic      viol,
    output logic      ctrl_we
);

    typedef struct packed {
        logic armed;
        logic blocked;
        logic per_we;
        logic per_re;
        logic ctrl_we;
    } gate_t;

    gate_t g_d;

    always_comb begin
        g_d = '0;
        unique case (cls.grp)
            GRP_PORT: g_d.armed = guard_en[BIT_PORT];
            GRP_INTR: g_d.armed = guard_en[BIT_INTR];
            GRP_CLK:  g_d.armed = guard_en[BIT_CLK];
            default:  g_d.armed = 1'b0;
        endcase
        g_d.blocked = cpu_we && g_d.armed;
        g_d.ctrl_we = cpu_we && cls.ctrl_hit;
        g_d.per_we  = cpu_we && !cls.ctrl_hit && !g_d.blocked;
        g_d.per_re  = cpu_re && !cls.ctrl_hit;
    end

    assign per_we  = g_d.per_we;
    assign per_re  = g_d.per_re;
    assign viol    = g_d.blocked;
    assign ctrl_we = g_d.ctrl_we;

    // R9: a violation never coincides with a forwarded write
    assert_viol_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (!per_we && cpu_we));

    // R5: port data writes are never stopped
    assert_pdata_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cls.pdata_hit) |-> per_we);

    // R10: reads outside the guard register are always forwarded
    assert_read_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_re && !cls.ctrl_hit) |-> per_re);

endmodule

// File: rtl/wg_filter.sv
module wg_filter
    import wg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned N_RANGES = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 20'hF0078,
    parameter logic [N_RANGES*ADDR_W-1:0] PDATA_LO = {20'hF0050, 20'hF0000},
    parameter logic [N_RANGES*ADDR_W-1:0] PDATA_HI = {20'hF005F, 20'hF000F},
    parameter logic [N_RANGES*ADDR_W-1:0] PORT_LO  = {20'hF0060, 20'hF0010},
    parameter logic [N_RANGES*ADDR_W-1:0] PORT_HI  = {20'hF006F, 20'hF003F},
    parameter logic [N_RANGES*ADDR_W-1:0] INTR_LO  = {20'hF0040, 20'hF00E0},
    parameter logic [N_RANGES*ADDR_W-1:0] INTR_HI  = {20'hF004F, 20'hF00FF},
    parameter logic [N_RANGES*ADDR_W-1:0] CLK_LO   = {20'hF0080, 20'hF00A0},
    parameter logic [N_RANGES*ADDR_W-1:0] CLK_HI   = {20'hF008F, 20'hF00AF}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    input  logic              cpu_re,
    output logic [7:0]        cpu_rdata,
    output logic [ADDR_W-1:0] per_addr,
    output logic [7:0]        per_wdata,
    output logic              per_we,
    output logic              per_re,
    input  logic [7:0]        per_rdata,
    output logic              guard_viol
);

    wg_class_t          cls;
    logic               ctrl_we;
    logic [GUARD_W-1:0] ctrl_q;

    wg_addr_class #(
        .ADDR_W   (ADDR_W),
        .N_RANGES (N_RANGES),
        .CTRL_ADDR(CTRL_ADDR),
        .PDATA_LO (PDATA_LO),
        .PDATA_HI (PDATA_HI),
        .PORT_LO  (PORT_LO),
        .PORT_HI  (PORT_HI),
        .INTR_LO  (INTR_LO),
        .INTR_HI  (INTR_HI),
        .CLK_LO   (CLK_LO),
        .CLK_HI   (CLK_HI)
    ) u_class (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (cpu_addr),
        .cls  (cls)
    );

    wg_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .cls     (cls),
        .guard_en(ctrl_q[2:0]),
        .cpu_we  (cpu_we),
        .cpu_re  (cpu_re),
        .per_we  (per_we),
        .per_re  (per_re),
        .viol    (guard_viol),
        .ctrl_we (ctrl_we)
    );

    wg_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_we),
        .wr_data(cpu_wdata),
        .ctrl_q (ctrl_q)
    );

    assign per_addr  = cpu_addr;
    assign per_wdata = cpu_wdata;
    assign cpu_rdata = cls.ctrl_hit ? ctrl_q : per_rdata;

    // R2: accesses to the guard register stay off the peripheral bus
    assert_ctrl_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == CTRL_ADDR) |-> (!per_we && !per_re && !guard_viol));

    // R12: a write with all three guard bits clear is never blocked
    assert_upper_bits_inert_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && ctrl_q[2:0] == 3'b000 && cpu_addr != CTRL_ADDR) |-> per_we);

endmodule

// File: tb/tb_wg_filter.sv
module tb_wg_filter;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [19:0] CTRL = 20'hF0078;

    localparam int C_NONE = 0, C_PORT = 1, C_INTR = 2, C_CLK = 3, C_PDATA = 4, C_CTRL = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic        cpu_re = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [19:0] per_addr;
    logic [7:0]  per_wdata;
    logic        per_we;
    logic        per_re;
    logic [7:0]  per_rdata = '0;
    logic        guard_viol;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] model = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    wg_filter dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_rdata(cpu_rdata), .per_addr(per_addr), .per_wdata(per_wdata),
        .per_we(per_we), .per_re(per_re), .per_rdata(per_rdata), .guard_viol(guard_viol)
    );

    function automatic int bclass(logic [19:0] a);
        if (a == CTRL) return C_CTRL;
        if ((a >= 20'hF0000 && a <= 20'hF000F) || (a >= 20'hF0050 && a <= 20'hF005F)) return C_PDATA;
        if ((a >= 20'hF0010 && a <= 20'hF003F) || (a >= 20'hF0060 && a <= 20'hF006F)) return C_PORT;
        if ((a >= 20'hF00E0 && a <= 20'hF00FF) || (a >= 20'hF0040 && a <= 20'hF004F)) return C_INTR;
        if ((a >= 20'hF00A0 && a <= 20'hF00AF) || (a >= 20'hF0080 && a <= 20'hF008F)) return C_CLK;
        return C_NONE;
    endfunction

    function automatic string req_of(int c);
        case (c)
            C_PORT:  return "R4";
            C_INTR:  return "R6";
            C_CLK:   return "R7";
            C_PDATA: return "R5";
            C_CTRL:  return "R2";
            default: return "R8";
        endcase
    endfunction

    function automatic logic exp_block(int c, logic we, logic [7:0] m);
        return we && ((c == C_PORT && m[2]) || (c == C_INTR && m[1]) || (c == C_CLK && m[0]));
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, check combinational outputs 1ns later,
    // then fold a guard-register write into the model for the rising edge.
    task automatic access(logic [19:0] a, logic [7:0] wd, logic we, logic re,
                          logic [7:0] prd, string tag);
        int c;
        logic blk;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = wd; cpu_we = we; cpu_re = re; per_rdata = prd;
        #1;
        c   = bclass(a);
        blk = exp_block(c, we, model);
        chk(tag == "" ? req_of(c) : tag, "per_we", 32'(per_we), 32'(we && c != C_CTRL && !blk));
        chk("R9", "guard_viol", 32'(guard_viol), 32'(blk));
        chk("R10", "per_re", 32'(per_re), 32'(re && c != C_CTRL));
        chk(c == C_CTRL ? "R2" : "R10", "cpu_rdata", 32'(cpu_rdata),
            32'(c == C_CTRL ? model : prd));
        chk("R11", "per_addr", 32'(per_addr), 32'(a));
        chk("R11", "per_wdata", 32'(per_wdata), 32'(wd));
        if (we && c == C_CTRL) model = wd & 8'hB7;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    function automatic logic [19:0] pick_addr(int k);
        case (k)
            0: return 20'hF0000 + 20'($urandom_range(0, 15));
            1: return 20'hF0010 + 20'($urandom_range(0, 47));
            2: return 20'hF0040 + 20'($urandom_range(0, 15));
            3: return 20'hF0050 + 20'($urandom_range(0, 31));
            4: return 20'hF0080 + 20'($urandom_range(0, 15));
            5: return 20'hF00A0 + 20'($urandom_range(0, 15));
            6: return 20'hF00E0 + 20'($urandom_range(0, 31));
            7: return CTRL;
            default: return 20'($urandom_range(20'hEFFF0, 20'hF0110));
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset value and open gates
        access(CTRL, 8'h00, 1'b0, 1'b1, 8'h5A, "R1");
        chk("R1", "reset guard", 32'(cpu_rdata), 32'h00);
        access(20'hF0010, 8'h11, 1'b1, 1'b0, 8'h00, "R1");
        access(20'hF00E0, 8'h22, 1'b1, 1'b0, 8'h00, "R1");
        access(20'hF00A0, 8'h33, 1'b1, 1'b0, 8'h00, "R1");

        // R2: reserved bits read as 0
        access(CTRL, 8'hFF, 1'b1, 1'b1, 8'h00, "R2");
        access(CTRL, 8'h00, 1'b0, 1'b1, 8'hC3, "R2");
        chk("R2", "masked readback", 32'(cpu_rdata), 32'hB7);

        // All guards armed: R4, R5, R6, R7, R8 and read pass-through
        access(20'hF003F, 8'hA1, 1'b1, 1'b1, 8'h44, "R4");
        access(20'hF0060, 8'hA2, 1'b1, 1'b0, 8'h00, "R4");
        access(20'hF000F, 8'hA3, 1'b1, 1'b0, 8'h00, "R5");
        access(20'hF0050, 8'hA4, 1'b1, 1'b0, 8'h00, "R5");
        access(20'hF00FF, 8'hA5, 1'b1, 1'b1, 8'h66, "R6");
        access(20'hF008F, 8'hA6, 1'b1, 1'b0, 8'h00, "R7");
        access(20'hF0070, 8'hA7, 1'b1, 1'b0, 8'h00, "R8");
        access(20'hF0090, 8'hA8, 1'b1, 1'b0, 8'h00, "R8");

        // R3: the guard register can be cleared while every guard is armed,
        // and the new value governs the very next access
        access(CTRL, 8'h04, 1'b1, 1'b0, 8'h00, "R3");
        access(20'hF00E0, 8'h01, 1'b1, 1'b0, 8'h00, "R3");
        access(20'hF0010, 8'h02, 1'b1, 1'b0, 8'h00, "R3");
        access(CTRL, 8'h00, 1'b0, 1'b1, 8'h00, "R3");
        chk("R3", "guard after rewrite", 32'(cpu_rdata), 32'h04);

        // R12: upper bits alone arm nothing
        access(CTRL, 8'hB0, 1'b1, 1'b0, 8'h00, "R12");
        access(20'hF0020, 8'h10, 1'b1, 1'b0, 8'h00, "R12");
        access(20'hF0045, 8'h10, 1'b1, 1'b0, 8'h00, "R12");
        access(20'hF00A5, 8'h10, 1'b1, 1'b0, 8'h00, "R12");

        // Constrained random mix of guard updates and bus traffic
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = $urandom_range(0, 9);
            access(pick_addr(k), 8'($urandom), 1'($urandom), 1'($urandom),
                   8'($urandom), "");
        end

        @(negedge clk);
        cpu_we = 1'b0; cpu_re = 1'b0;
        finish_run();
    end

endmodule